// File: doc/BRIEF.md
# SDRAM Power-Up Initialization Sequencer

This block sits on the controller side of an SDRAM interface and takes the memory from power-up to a usable state. It holds the command bus in the deselected (inhibit) state until a clock-stable input goes high. It then drives a timed window of NOP commands and issues a precharge to all banks. Two auto-refresh commands follow, and then a mode-register load that carries a fixed configuration word. The next command of the sequence waits out its own gap after each of these commands. When the last gap has passed, a ready flag rises and hands the bus to the normal-traffic controller.

All pins are registered, so every command is driven for exactly one clock cycle from a flop. The length of the power-up window and the command-to-command gaps after precharge, refresh and mode load are parameters given in clock cycles. The mode word is a parameter as well. If clock-stable drops at any point, even after ready, the sequencer deselects the device and restarts the whole bring-up from the power-up window. The gap parameters must be at least 2 and the power-up window at least 1.

Top module: `sdram_bringup`

## Requirements
- R1: While reset is active, and on the cycle after any edge where clk_stable is sampled low, the pins carry INHIBIT (cs_n=1, ras_n=1, cas_n=1, we_n=1), addr=0, ba=0 and ready=0.
- R2: After the first edge that samples clk_stable high, the pins carry NOP ({cs_n,ras_n,cas_n,we_n}=0111, addr=0, ba=0) for exactly PWRUP_CYC cycles, and then the first non-NOP command appears.
- R3: The first command after the power-up window is PRECHARGE (0111 becomes 0010) for one cycle, with addr bit 10 high, all other addr bits 0 and ba=0.
- R4: The next command is an AUTO REFRESH (0001), issued PRE_GAP cycles after the PRECHARGE. NOP is driven on every cycle between the two.
- R5: Exactly two AUTO REFRESH commands are issued, each for one cycle with addr=0 and ba=0. The second comes REF_GAP cycles after the first, and NOP is driven in between.
- R6: REF_GAP cycles after the second refresh, LOAD MODE (0000) is driven for one cycle with addr equal to MODE_WORD and ba=0.
- R7: MRD_GAP cycles after LOAD MODE, ready rises. The pins carry NOP between the two. From then on, while clk_stable stays high, ready stays high and the pins stay at NOP with addr=0.
- R8: A drop of clk_stable at any step, including after ready, deselects the device and clears ready on the next cycle. When clk_stable returns, the full sequence of R2 to R7 runs again from the start, with the full power-up window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clk_stable | input | 1 | High when the memory clock meets its timing; gates the sequence |
| cs_n | output | 1 | Chip select, active low |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| addr | output | ADDR_W | Address bus (all-banks flag on bit 10, mode word on load) |
| ba | output | BA_W | Bank address |
| ready | output | 1 | Bring-up complete; bus may be handed over |

## Verification
A wrong step or a mis-loaded wait counter shows at the pins as a command that appears one or more cycles early or late, or as a command code that does not belong at that point. The bench compares every cycle of the bus against a position-indexed schedule, so such an error shows up in the cycle it happens. A corrupted step after ready would show at once as a non-NOP code or a missing ready. A missed restart shows one cycle after clk_stable falls, as a selected chip or a ready that is still high.

// File: rtl/sdram_bringup_pkg.sv
package sdram_bringup_pkg;

    // Command codes, bit order {cs_n, ras_n, cas_n, we_n}
    typedef enum logic [3:0] {
        CMD_MRS = 4'b0000,
        CMD_REF = 4'b0001,
        CMD_PRE = 4'b0010,
        CMD_NOP = 4'b0111,
        CMD_INH = 4'b1111
    } cmd_e;

    // Bring-up steps
    typedef enum logic [3:0] {
        ST_IDLE  = 4'd0,
        ST_PWRUP = 4'd1,
        ST_PRE   = 4'd2,
        ST_RP    = 4'd3,
        ST_REF1  = 4'd4,
        ST_RFC1  = 4'd5,
        ST_REF2  = 4'd6,
        ST_RFC2  = 4'd7,
        ST_MRS   = 4'd8,
        ST_MRD   = 4'd9,
        ST_READY = 4'd10
    } step_e;

    // Bit of the address bus that selects all banks on a precharge
    localparam int ALL_BANKS_BIT = 10;

endpackage

// File: rtl/sdram_wait_timer.sv
module sdram_wait_timer #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expired
);
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cnt_d;

    always_comb begin
        cnt_d = cnt_q;
        if (load) begin
            cnt_d = load_val;
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign expired = (cnt_q == '0);
endmodule

// File: rtl/sdram_cmd_encode.sv
module sdram_cmd_encode
    import sdram_bringup_pkg::*;
#(
    parameter int              ADDR_W    = 12,
    parameter int              BA_W      = 2,
    parameter logic [ADDR_W-1:0] MODE_WORD = '0
) (
    input  step_e             step,
    output logic [3:0]        cmd,
    output logic [ADDR_W-1:0] addr,
    output logic [BA_W-1:0]   ba
);
    always_comb begin
        cmd  = CMD_NOP;
        addr = '0;
        ba   = '0;
        unique case (step)
            ST_IDLE: cmd = CMD_INH;
            ST_PRE: begin
                cmd                 = CMD_PRE;
                addr[ALL_BANKS_BIT] = 1'b1;
            end
            ST_REF1, ST_REF2: cmd = CMD_REF;
            ST_MRS: begin
                cmd  = CMD_MRS;
                addr = MODE_WORD;
            end
            default: cmd = CMD_NOP;
        endcase
    end
endmodule

// File: rtl/sdram_bringup.sv
module sdram_bringup
    import sdram_bringup_pkg::*;
#(
    parameter int                ADDR_W    = 12,
    parameter int                BA_W      = 2,
    parameter int                PWRUP_CYC = 25000,
    parameter int                PRE_GAP   = 5,
    parameter int                REF_GAP   = 17,
    parameter int                MRD_GAP   = 2,
    parameter logic [ADDR_W-1:0] MODE_WORD = 12'h033
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clk_stable,
    output logic              cs_n,
    output logic              ras_n,
    output logic              cas_n,
    output logic              we_n,
    output logic [ADDR_W-1:0] addr,
    output logic [BA_W-1:0]   ba,
    output logic              ready
);
    localparam int MAX_GAP_A = (PRE_GAP > REF_GAP) ? PRE_GAP : REF_GAP;
    localparam int MAX_GAP_B = (MAX_GAP_A > MRD_GAP) ? MAX_GAP_A : MRD_GAP;
    localparam int MAX_CYC   = (MAX_GAP_B > PWRUP_CYC) ? MAX_GAP_B : PWRUP_CYC;
    localparam int CNT_W     = $clog2(MAX_CYC + 1);

    typedef struct packed {
        step_e             step;
        logic [3:0]        cmd;
        logic [ADDR_W-1:0] addr;
        logic [BA_W-1:0]   ba;
        logic              ready;
    } seq_t;

    seq_t seq_q;
    seq_t seq_d;

    logic             tmr_load;
    logic [CNT_W-1:0] tmr_val;
    logic             tmr_expired;

    logic [3:0]        enc_cmd;
    logic [ADDR_W-1:0] enc_addr;
    logic [BA_W-1:0]   enc_ba;
    step_e             next_step;

    sdram_wait_timer #(.CNT_W(CNT_W)) i_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (tmr_load),
        .load_val(tmr_val),
        .expired (tmr_expired)
    );

    sdram_cmd_encode #(
        .ADDR_W   (ADDR_W),
        .BA_W     (BA_W),
        .MODE_WORD(MODE_WORD)
    ) i_encode (
        .step(next_step),
        .cmd (enc_cmd),
        .addr(enc_addr),
        .ba  (enc_ba)
    );

    // Step transitions
    always_comb begin
        next_step = seq_q.step;
        if (!clk_stable) begin
            next_step = ST_IDLE;
        end else begin
            unique case (seq_q.step)
                ST_IDLE:  next_step = ST_PWRUP;
                ST_PWRUP: if (tmr_expired) next_step = ST_PRE;
                ST_PRE:   next_step = ST_RP;
                ST_RP:    if (tmr_expired) next_step = ST_REF1;
                ST_REF1:  next_step = ST_RFC1;
                ST_RFC1:  if (tmr_expired) next_step = ST_REF2;
                ST_REF2:  next_step = ST_RFC2;
                ST_RFC2:  if (tmr_expired) next_step = ST_MRS;
                ST_MRS:   next_step = ST_MRD;
                ST_MRD:   if (tmr_expired) next_step = ST_READY;
                ST_READY: next_step = ST_READY;
                default:  next_step = ST_IDLE;
            endcase
        end
    end

    // Timer load on entry to a wait step, registered pin values
    always_comb begin
        tmr_load = 1'b0;
        tmr_val  = '0;
        if (next_step != seq_q.step) begin
            unique case (next_step)
                ST_PWRUP: begin tmr_load = 1'b1; tmr_val = CNT_W'(PWRUP_CYC - 1); end
                ST_RP:    begin tmr_load = 1'b1; tmr_val = CNT_W'(PRE_GAP - 2);   end
                ST_RFC1,
                ST_RFC2:  begin tmr_load = 1'b1; tmr_val = CNT_W'(REF_GAP - 2);   end
                ST_MRD:   begin tmr_load = 1'b1; tmr_val = CNT_W'(MRD_GAP - 2);   end
                default:  begin tmr_load = 1'b0; tmr_val = '0;                    end
            endcase
        end

        seq_d       = seq_q;
        seq_d.step  = next_step;
        seq_d.cmd   = enc_cmd;
        seq_d.addr  = enc_addr;
        seq_d.ba    = enc_ba;
        seq_d.ready = (next_step == ST_READY);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q.step  <= ST_IDLE;
            seq_q.cmd   <= CMD_INH;
            seq_q.addr  <= '0;
            seq_q.ba    <= '0;
            seq_q.ready <= 1'b0;
        end else begin
            seq_q <= seq_d;
        end
    end

    assign {cs_n, ras_n, cas_n, we_n} = seq_q.cmd;
    assign addr  = seq_q.addr;
    assign ba    = seq_q.ba;
    assign ready = seq_q.ready;
endmodule

// File: rtl/sdram_bringup_chk.sv
module sdram_bringup_chk #(
    parameter int                ADDR_W    = 12,
    parameter int                BA_W      = 2,
    parameter int                PWRUP_CYC = 25000,
    parameter logic [ADDR_W-1:0] MODE_WORD = 12'h033
) (
    input logic              clk,
    input logic              rst_n,
    input logic              clk_stable,
    input logic              cs_n,
    input logic              ras_n,
    input logic              cas_n,
    input logic              we_n,
    input logic [ADDR_W-1:0] addr,
    input logic [BA_W-1:0]   ba,
    input logic              ready
);
    logic [3:0]  bus;
    logic [31:0] nop_run_q;
    assign bus = {cs_n, ras_n, cas_n, we_n};

    // Length of the current unbroken NOP stretch
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            nop_run_q <= '0;
        end else if (bus == 4'b0111) begin
            if (nop_run_q != 32'hFFFF_FFFF) nop_run_q <= nop_run_q + 1;
        end else begin
            nop_run_q <= '0;
        end
    end

    p_inhibit_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !clk_stable |=> (cs_n && !ready));

    // R8: after clock loss the bus is deselected
    p_restart_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(clk_stable) |=> (bus == 4'b1111));

    p_pwrup_gap_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus == 4'b0010) |-> (nop_run_q == 32'(PWRUP_CYC)));

    p_pre_all_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus == 4'b0010) |-> (addr[10] && ba == '0));

    p_ref_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (bus == 4'b0001) |=> (bus != 4'b0001));

    p_mode_word_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (bus == 4'b0000) |-> (addr == MODE_WORD && ba == '0));

    p_ready_nop_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ready |-> (bus == 4'b0111 && addr == '0));

    p_ready_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && clk_stable) |=> ready);
endmodule

bind sdram_bringup sdram_bringup_chk #(
    .ADDR_W   (ADDR_W),
    .BA_W     (BA_W),
    .PWRUP_CYC(PWRUP_CYC),
    .MODE_WORD(MODE_WORD)
) i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .clk_stable(clk_stable),
    .cs_n      (cs_n),
    .ras_n     (ras_n),
    .cas_n     (cas_n),
    .we_n      (we_n),
    .addr      (addr),
    .ba        (ba),
    .ready     (ready)
);

// File: tb/test_sdram_bringup.sv
module test_sdram_bringup;
    localparam int          AW   = 12;
    localparam int          BW   = 2;
    localparam int          P    = 24;
    localparam int          RP   = 3;
    localparam int          RFC  = 6;
    localparam int          MRD  = 2;
    localparam logic [11:0] MODE = 12'h233;
    localparam int          TOTAL = P + RP + 2 * RFC + MRD;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          clk_stable = 1'b0;
    logic          cs_n, ras_n, cas_n, we_n, ready;
    logic [AW-1:0] addr;
    logic [BW-1:0] ba;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    sdram_bringup #(
        .ADDR_W(AW), .BA_W(BW), .PWRUP_CYC(P), .PRE_GAP(RP),
        .REF_GAP(RFC), .MRD_GAP(MRD), .MODE_WORD(MODE)
    ) i_sdram_bringup (
        .clk(clk), .rst_n(rst_n), .clk_stable(clk_stable),
        .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
        .addr(addr), .ba(ba), .ready(ready)
    );

    // Expected bus at position k after clk_stable was first sampled high
    function automatic logic [3:0] exp_cmd(int k);
        if (k == P)                 return 4'b0010;
        if (k == P + RP)            return 4'b0001;
        if (k == P + RP + RFC)      return 4'b0001;
        if (k == P + RP + 2 * RFC)  return 4'b0000;
        return 4'b0111;
    endfunction

    function automatic logic [AW-1:0] exp_addr(int k);
        if (k == P)                return 12'h400;
        if (k == P + RP + 2 * RFC) return MODE;
        return '0;
    endfunction

    function automatic string req_of(int k);
        if (k < P)                 return "R2";
        if (k == P)                return "R3";
        if (k <= P + RP)           return "R4";
        if (k <= P + RP + RFC)     return "R5";
        if (k <= P + RP + 2 * RFC) return "R6";
        return "R7";
    endfunction

    task automatic check(string req, logic [3:0] c, logic [AW-1:0] a,
                         logic [BW-1:0] b, logic r);
        logic [3:0] act;
        act = {cs_n, ras_n, cas_n, we_n};
        checks++;
        if (act !== c || addr !== a || ba !== b || ready !== r) begin
            fails++;
            $display("FAIL %s: cmd=%b addr=%h ba=%h ready=%b, expected cmd=%b addr=%h ba=%h ready=%b",
                     req, act, addr, ba, ready, c, a, b, r);
        end
    endtask

    // Run the sequence; abort_at < 0 means run to ready and a bit beyond
    task automatic run_seq(int abort_at);
        clk_stable = 1'b1;
        for (int k = 0; k <= TOTAL + 3; k++) begin
            @(negedge clk);
            check(req_of(k), exp_cmd(k), exp_addr(k), '0, k >= TOTAL);
            if (k == abort_at) break;
        end
        clk_stable = 1'b0;
        @(negedge clk);
        check("R8", 4'b1111, '0, '0, 1'b0);
    endtask

    task automatic idle_cycles(int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            check("R1", 4'b1111, '0, '0, 1'b0);
        end
    endtask

    initial begin
        while (!done) begin
            @(posedge clk);
            cycles++;
            if (cycles > 150000) begin
                fails++;
                $display("FAIL watchdog: cycles=%0d expected below 150000", cycles);
                $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
                $finish;
            end
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        // R1: reset state, clk_stable high is ignored during reset
        clk_stable = 1'b1;
        repeat (3) @(negedge clk);
        check("R1", 4'b1111, '0, '0, 1'b0);
        clk_stable = 1'b0;
        rst_n = 1'b1;
        idle_cycles(3);

        // Directed: full run, then loss of clock after ready (R7, R8)
        run_seq(-1);
        idle_cycles(2);
        // Directed aborts at the corner points, each followed by a full run
        run_seq(0);
        idle_cycles(1);
        run_seq(P);
        idle_cycles(1);
        run_seq(P + RP);
        idle_cycles(2);
        run_seq(TOTAL - 1);
        idle_cycles(1);
        run_seq(-1);

        // Random abort points mixed with complete runs
        for (int it = 0; it < 16; it++) begin
            int ab;
            ab = int'($urandom_range(TOTAL + 3, 0));
            if ($urandom_range(3, 0) == 0) ab = -1;
            idle_cycles(int'($urandom_range(4, 1)));
            run_seq(ab);
        end
        idle_cycles(2);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule